// File: doc/BRIEF.md
# Capture Ring Buffer Controller

This block takes audio sample words from a serial receiver and stores them in a small on-chip circular buffer while recording is switched on. The host drains the buffer one word at a time through a data register. Each read returns the oldest stored word and moves the read position on by one. The host can also read both buffer positions, a status register and its enable settings.

Two interrupt sources share one request line. The first is a fill-level condition whose threshold is a programmable fraction of the buffer. The second is a sticky overrun condition, raised when a sample arrives and no slot is free.

A built-in pattern generator can replace the live input for bring-up. It produces either a constant 0x55 or a pseudo-random sequence. Every stored word is cut down to the selected sample width and kept right-justified.

Top module: `capbuf_ctrl`

Register word addresses on `reg_addr`:

| Address | Register | Content |
|---|---|---|
| 0 | data | read only; reading pops one word |
| 1 | write position | read only |
| 2 | read position | read only |
| 3 | test | bit0 pattern on, bit1 pattern select |
| 4 | control | bit0 buffer clear (write only, pulse), bit1 record, bits[3:2] width |
| 5 | status | bit0 level, bit1 overrun |
| 6 | enable | bits[1:0] threshold, bit2 overrun enable |

## Requirements
- R1: A `smp_valid` strobe stores a word only while the record bit (control bit1) is 1. With record at 0, the write position does not move.
- R2: A read of address 0 returns the oldest stored word and advances the read position by one. A read of address 0 with the buffer empty returns 0 and leaves the read position unchanged.
- R3: Addresses 1 and 2 return the write and read slot index times two, zero-extended. Each slot counts as four bytes, so this value is the byte address divided by two.
- R4: The fill level is (write index - read index) mod DEPTH. The threshold field (enable bits[1:0]) selects the level at which status bit0 and `irq_out` assert: 00 never, 01 DEPTH/8, 10 DEPTH/4, 11 DEPTH/2. The condition is level >= threshold.
- R5: The level condition drops as soon as host reads bring the fill level below the selected threshold.
- R6: A strobe that arrives while DEPTH-1 words are stored is dropped, and status bit1 is set. Bit1 stays set until the status register is read. The read itself still returns 1 in bit1.
- R7: The overrun condition drives `irq_out` only while the overrun enable (enable bit2) is 1.
- R8: Writing the control register with bit0 at 1 does the following in one cycle:
  - clears both positions and the overrun flag;
  - reseeds the pattern generator;
  - loads the record and width fields from the same write.
- R9: With test bit0 at 1 and bit1 at 0, each strobe stores 0x55 in place of `smp_data`.
- R10: With test bits[1:0] at 11, each strobe stores the current value of a 16-bit register, which then advances. The register is seeded to 0xACE1 and advances as next = {cur[14:0], cur[15]^cur[13]^cur[12]^cur[10]}.
- R11: The width field (control bits[3:2]) keeps the low 16, 18, 20 or 24 bits of each sample for codes 00, 01, 10 and 11, and clears the bits above.
- R12: After a synchronous `rst`, both positions, the status register and `irq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: a sample is present |
| smp_data | input | 24 | Live sample, right-justified |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (has side effects at addresses 0 and 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 24 | Register read data, combinational from the address |
| irq_out | output | 1 | Interrupt request, level |

## Verification
A strobe or a register write takes effect on the rising edge where it is sampled. The positions, the status bits and `irq_out` therefore show the new value from that edge onward, and the bench checks them one time step after that edge. Read data is combinational from the current state, so the bench samples `reg_rdata` in the same cycle as the read strobe, before the edge that pops the word or clears the overrun flag. Inputs are driven on the falling edge, which keeps every sample point clear of the active edge.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

    localparam int SMP_W  = 24;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_WPOS = 3'd1,
        A_RPOS = 3'd2,
        A_TEST = 3'd3,
        A_CTRL = 3'd4,
        A_STAT = 3'd5,
        A_IEN  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] width;
        logic       record;
    } ctrl_t;

    typedef struct packed {
        logic rnd;
        logic sim;
    } test_t;

    typedef struct packed {
        logic       ovr_en;
        logic [1:0] thr;
    } ien_t;

    function automatic logic [SMP_W-1:0] width_mask(input logic [1:0] w);
        case (w)
            2'b00:   return 24'h00FFFF;
            2'b01:   return 24'h03FFFF;
            2'b10:   return 24'h0FFFFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/capbuf_src.sv
module capbuf_src
    import capbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             strobe,
    input  logic [SMP_W-1:0] live,
    input  test_t            test,
    input  logic [1:0]       width,
    output logic [SMP_W-1:0] word
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [SMP_W-1:0]  raw;

    always_ff @(posedge clk) begin
        if (rst || clr)
            lfsr_q <= LFSR_SEED;
        else if (strobe && test.sim && test.rnd)
            lfsr_q <= lfsr_step(lfsr_q);
    end

    always_comb begin
        if (!test.sim)
            raw = live;
        else if (test.rnd)
            raw = {{(SMP_W-LFSR_W){1'b0}}, lfsr_q};
        else
            raw = 24'h000055;
        word = raw & width_mask(width);
    end
endmodule

// File: rtl/capbuf_ring.sv
module capbuf_ring
    import capbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [SMP_W-1:0] push_word,
    input  logic             pop,
    output logic [AW-1:0]    wr_idx,
    output logic [AW-1:0]    rd_idx,
    output logic [AW-1:0]    level,
    output logic             empty,
    output logic             drop,
    output logic [SMP_W-1:0] head
);
    logic [SMP_W-1:0] mem [DEPTH];
    logic             full;

    assign level = wr_idx - rd_idx;
    assign empty = (wr_idx == rd_idx);
    assign full  = ((wr_idx + AW'(1)) == rd_idx);
    assign drop  = push && full;
    assign head  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_idx] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push && !full)
                wr_idx <= wr_idx + AW'(1);
            if (pop && !empty)
                rd_idx <= rd_idx + AW'(1);
        end
    end
endmodule

// File: rtl/capbuf_irq.sv
module capbuf_irq
    import capbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [AW-1:0] level,
    input  ien_t          ien,
    input  logic          drop,
    input  logic          stat_rd,
    output logic          lvl_hit,
    output logic          ovr_flag,
    output logic          irq
);
    localparam logic [AW-1:0] T_EIGHTH  = AW'(DEPTH / 8);
    localparam logic [AW-1:0] T_QUARTER = AW'(DEPTH / 4);
    localparam logic [AW-1:0] T_HALF    = AW'(DEPTH / 2);

    logic [AW-1:0] thresh;

    always_comb begin
        case (ien.thr)
            2'b01:   thresh = T_EIGHTH;
            2'b10:   thresh = T_QUARTER;
            default: thresh = T_HALF;
        endcase
        lvl_hit = (ien.thr != 2'b00) && (level >= thresh);
        irq     = lvl_hit || (ovr_flag && ien.ovr_en);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            ovr_flag <= 1'b0;
        else if (drop)
            ovr_flag <= 1'b1;
        else if (stat_rd)
            ovr_flag <= 1'b0;
    end
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
    import capbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [2:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [SMP_W-1:0] reg_rdata,
    output logic             irq_out
);
    localparam int AW = $clog2(DEPTH);

    ctrl_t ctrl_q;
    test_t test_q;
    ien_t  ien_q;

    logic             rec_en;
    logic             soft_clr;
    logic             push;
    logic             pop;
    logic             stat_rd;
    logic [SMP_W-1:0] src_word;
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    rd_idx;
    logic [AW-1:0]    level;
    logic             empty;
    logic             drop;
    logic [SMP_W-1:0] head;
    logic             lvl_hit;
    logic             ovr_flag;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[15:4];
    assign rec_en   = ctrl_q.record;
    assign soft_clr = reg_we && (reg_addr == A_CTRL) && reg_wdata[0];
    assign push     = smp_valid && rec_en;
    assign pop      = reg_re && (reg_addr == A_DATA);
    assign stat_rd  = reg_re && (reg_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            test_q <= '0;
            ien_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_TEST:  test_q <= reg_wdata[1:0];
                A_CTRL:  ctrl_q <= reg_wdata[3:1];
                A_IEN:   ien_q  <= reg_wdata[2:0];
                default: ;
            endcase
        end
    end

    capbuf_src u_src (
        .clk    (clk),
        .rst    (rst),
        .clr    (soft_clr),
        .strobe (push),
        .live   (smp_data),
        .test   (test_q),
        .width  (ctrl_q.width),
        .word   (src_word)
    );

    capbuf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_clr),
        .push      (push),
        .push_word (src_word),
        .pop       (pop),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .level     (level),
        .empty     (empty),
        .drop      (drop),
        .head      (head)
    );

    capbuf_irq #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_clr),
        .level    (level),
        .ien      (ien_q),
        .drop     (drop),
        .stat_rd  (stat_rd),
        .lvl_hit  (lvl_hit),
        .ovr_flag (ovr_flag),
        .irq      (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata = empty ? '0 : head;
            A_WPOS:  reg_rdata = SMP_W'({wr_idx, 1'b0});
            A_RPOS:  reg_rdata = SMP_W'({rd_idx, 1'b0});
            A_TEST:  reg_rdata = SMP_W'(test_q);
            A_CTRL:  reg_rdata = SMP_W'({ctrl_q, 1'b0});
            A_STAT:  reg_rdata = SMP_W'({ovr_flag, lvl_hit});
            A_IEN:   reg_rdata = SMP_W'(ien_q);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic          reg_re,
    input logic [2:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic [23:0]   reg_rdata,
    input logic [AW-1:0] wr_idx,
    input logic [AW-1:0] rd_idx,
    input logic          ovr_flag,
    input logic          rec_en
);
    logic clr_w;
    assign clr_w = reg_we && (reg_addr == 3'd4) && reg_wdata[0];

    // R2: popping an empty buffer yields zero
    p_empty_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == 3'd0 && wr_idx == rd_idx) |-> (reg_rdata == 24'd0));

    // R2: read position only moves on a data read
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!(reg_re && reg_addr == 3'd0) && !clr_w) |=> $stable(rd_idx));

    // R1: no capture while record is off
    p_no_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (!rec_en && !clr_w) |=> $stable(wr_idx));

    // R6: overrun stays until status is read
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !(reg_re && reg_addr == 3'd5) && !clr_w) |=> ovr_flag);

    // R8: buffer clear empties everything
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> (wr_idx == '0 && rd_idx == '0 && !ovr_flag));
endmodule

bind capbuf_ctrl capbuf_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_capbuf_ctrl.sv
module tb_capbuf_ctrl;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    capbuf_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // {width, input sample, expected stored word}
    localparam logic [49:0] FMT_VEC [5] = '{
        {2'b11, 24'hABCDEF, 24'hABCDEF},
        {2'b00, 24'hABCDEF, 24'h00CDEF},
        {2'b01, 24'hFFFFFF, 24'h03FFFF},
        {2'b10, 24'h9A5A5A, 24'h0A5A5A},
        {2'b00, 24'h12FFFF, 24'h00FFFF}
    };

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] v);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic push(input logic [23:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [15:0] l;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        rd(3'd1, v); chk("R12 wpos", v, 24'd0);
        rd(3'd2, v); chk("R12 rpos", v, 24'd0);
        rd(3'd5, v); chk("R12 status", v, 24'd0);
        chk("R12 irq", {23'd0, irq_out}, 24'd0);
        rd(3'd0, v); chk("R2 empty after reset", v, 24'd0);

        // R1 record off
        push(24'h111111); push(24'h222222); push(24'h333333);
        rd(3'd1, v); chk("R1 no capture", v, 24'd0);

        // R2/R3 record on, 24-bit width
        wr(3'd4, 16'h000E);
        push(24'h000AAA); push(24'h000BBB); push(24'h000CCC);
        rd(3'd1, v); chk("R3 wpos", v, 24'd6);
        rd(3'd0, v); chk("R2 first", v, 24'h000AAA);
        rd(3'd0, v); chk("R2 second", v, 24'h000BBB);
        rd(3'd0, v); chk("R2 third", v, 24'h000CCC);
        rd(3'd2, v); chk("R3 rpos", v, 24'd6);
        rd(3'd0, v); chk("R2 empty read", v, 24'd0);
        rd(3'd2, v); chk("R2 rpos held", v, 24'd6);

        // R11 width table
        for (int k = 0; k < 5; k++) begin
            wr(3'd4, 16'({FMT_VEC[k][49:48], 2'b10}));
            push(FMT_VEC[k][47:24]);
            rd(3'd0, v); chk("R11 width", v, FMT_VEC[k][23:0]);
        end

        // R4/R5 level thresholds (DEPTH 16: 2, 4, 8)
        wr(3'd4, 16'h000F);
        wr(3'd6, 16'h0001);
        push(24'h1);
        chk("R4 below eighth", {23'd0, irq_out}, 24'd0);
        push(24'h2);
        chk("R4 at eighth", {23'd0, irq_out}, 24'd1);
        wr(3'd6, 16'h0002);
        chk("R4 below quarter", {23'd0, irq_out}, 24'd0);
        push(24'h3); push(24'h4);
        chk("R4 at quarter", {23'd0, irq_out}, 24'd1);
        wr(3'd6, 16'h0003);
        chk("R4 below half", {23'd0, irq_out}, 24'd0);
        for (int k = 0; k < 4; k++) push(24'h5);
        rd(3'd5, v); chk("R4 status level bit", v, 24'd1);
        chk("R4 at half", {23'd0, irq_out}, 24'd1);
        wr(3'd6, 16'h0000);
        chk("R4 disabled", {23'd0, irq_out}, 24'd0);
        wr(3'd6, 16'h0003);
        rd(3'd0, v);
        chk("R5 drops below half", {23'd0, irq_out}, 24'd0);

        // R8 clear, then R6/R7 overrun
        wr(3'd4, 16'h000F);
        rd(3'd1, v); chk("R8 wpos cleared", v, 24'd0);
        rd(3'd2, v); chk("R8 rpos cleared", v, 24'd0);
        wr(3'd6, 16'h0000);
        for (int k = 0; k < DEPTH - 1; k++) push(24'(k + 1));
        chk("R6 no flag when just full", {23'd0, irq_out}, 24'd0);
        push(24'hDEAD00);
        rd(3'd1, v); chk("R6 dropped word", v, 24'd30);
        chk("R7 masked", {23'd0, irq_out}, 24'd0);
        wr(3'd6, 16'h0004);
        chk("R7 enabled", {23'd0, irq_out}, 24'd1);
        rd(3'd5, v); chk("R6 status set", v, 24'd2);
        rd(3'd5, v); chk("R6 cleared by read", v, 24'd0);
        chk("R7 irq off after clear", {23'd0, irq_out}, 24'd0);
        rd(3'd0, v); chk("R6 oldest kept", v, 24'd1);
        wr(3'd4, 16'h000F);
        rd(3'd5, v); chk("R8 status cleared", v, 24'd0);

        // R9 constant pattern
        wr(3'd3, 16'h0001);
        push(24'hABCDEF);
        rd(3'd0, v); chk("R9 const", v, 24'h000055);

        // R10 pseudo-random pattern
        wr(3'd3, 16'h0003);
        wr(3'd4, 16'h000F);
        push(24'h0); push(24'h0); push(24'h0);
        l = 16'hACE1;
        for (int k = 0; k < 3; k++) begin
            rd(3'd0, v); chk("R10 lfsr", v, {8'd0, l});
            l = nxt(l);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule